// File: doc/BRIEF.md
# Accumulator ALU with Copy-Bit Flags

This block is the arithmetic and logic stage of a small 8-bit accumulator datapath. In each cycle it takes an operation code, two 16-bit operand buses, a 3-bit bit-number, a 16-bit effective address and the incoming flag byte. It registers a 16-bit result and a new flag byte, and both appear one clock later. Byte operations use the low bytes of the operand buses. The register-pair additions use the full 16 bits.

The supported operations are:
- 8-bit add and add-with-carry.
- 8-bit AND.
- Single-bit test, plain or indexed.
- Carry complement.
- 16-bit add and add-with-carry.

Besides the usual status bits, the flag byte carries two copy bits. They normally mirror result bits 5 and 3. The carry complement takes them from the accumulator instead, and the indexed bit test takes them from the effective address.

Top module: `acc_alu`

## Requirements
- R1: While `rst_n` is low, `result_o` and `flags_o` are zero. Outside reset, outputs show the operation whose inputs were present at the previous rising clock edge (latency of one cycle).
- R2: Flag byte layout, bit 7 to bit 0: S, Z, U5, H, U3, PV, N, C. U5 and U3 are the copy bits. Every operation clears N.
- R3: Op 0 (add) and op 1 (add-with-carry) compute r = lhs[7:0] + rhs[7:0], plus the incoming C for op 1. The result is `{8'h00, r}`. S=r[7], Z=(r==0), U5=r[5], U3=r[3]. H is the carry out of bit 3, PV is signed overflow, and C is bit 8 of the sum.
- R4: Op 2 (AND): r = lhs[7:0] & rhs[7:0], and the result is `{8'h00, r}`. H=1, C=0, PV=1 when r has an even number of ones. S, Z, U5 and U3 follow r.
- R5: Op 3 (bit test): t = lhs[7:0] & (1 << bit_sel). S=t[7], Z=(t==0), PV=(t==0), H=1, U5=t[5], U3=t[3]. C is unchanged. The result equals lhs.
- R6: Op 4 (indexed bit test) behaves as R5, except that U5 = ea[13] and U3 = ea[11].
- R7: Op 5 (carry complement) sets H to the old C and C to the inverted old C. It sets U5 = old U5 | lhs[5] and U3 = old U3 | lhs[3]. S, Z and PV are unchanged. The result equals lhs.
- R8: Op 6 (16-bit add) sets the result to (lhs + rhs) mod 2^16. H is the carry from bit 11 into bit 12, C is the carry out of bit 15, U5 = sum[13] and U3 = sum[11]. S, Z and PV are unchanged.
- R9: Op 7 (16-bit add-with-carry) behaves as R8 with the incoming C added. It also sets S=sum[15], Z=(sum==0) and PV to 16-bit signed overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_i | input | 3 | Operation code (0..7) |
| lhs_i | input | 16 | First operand / accumulator (low byte) |
| rhs_i | input | 16 | Second operand |
| bit_sel_i | input | 3 | Bit number for bit tests |
| ea_i | input | 16 | Effective address for indexed bit test |
| flags_i | input | 8 | Incoming flag byte |
| result_o | output | 16 | Registered result |
| flags_o | output | 8 | Registered flag byte |

## Verification
The hardest cases to reach are the ones where a copy bit comes from something other than the result. In these cases the copy bit must disagree with the result bits, which no ordinary add or AND can produce. The stimulus therefore sets up each such case deliberately:
- Indexed bit tests use effective addresses whose bits 13 and 11 differ from the masked operand.
- Carry complements are driven with each combination of old copy bits and accumulator bits 5 and 3.
- A 16-bit add is run with S, Z and PV preset in the incoming flags, to show that they survive.

// File: rtl/alu_pkg.sv
package alu_pkg;

    localparam int BYTE_W = 8;
    localparam int WORD_W = 16;

    typedef enum logic [2:0] {
        OP_ADD8  = 3'd0,
        OP_ADC8  = 3'd1,
        OP_AND8  = 3'd2,
        OP_BTST  = 3'd3,
        OP_BTSTX = 3'd4,
        OP_CCF   = 3'd5,
        OP_ADD16 = 3'd6,
        OP_ADC16 = 3'd7
    } alu_op_e;

    // flag byte positions (R2)
    localparam int FL_C  = 0;
    localparam int FL_N  = 1;
    localparam int FL_PV = 2;
    localparam int FL_U3 = 3;
    localparam int FL_H  = 4;
    localparam int FL_U5 = 5;
    localparam int FL_Z  = 6;
    localparam int FL_S  = 7;

    typedef struct packed {
        logic [WORD_W-1:0] res;
        logic [BYTE_W-1:0] flg;
        logic              vld;
    } alu_state_t;

    function automatic logic even_ones(input logic [BYTE_W-1:0] v);
        return ~(^v);
    endfunction

endpackage

// File: rtl/alu_adder.sv
module alu_adder #(
    parameter int W  = 8,
    parameter int HB = 4
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         cin_i,
    output logic [W-1:0] sum_o,
    output logic         half_o,
    output logic         carry_o,
    output logic         ovf_o
);
    logic [HB:0] low_sum;
    logic [W:0]  full_sum;

    always_comb begin
        low_sum  = {1'b0, a_i[HB-1:0]} + {1'b0, b_i[HB-1:0]} + {{HB{1'b0}}, cin_i};
        full_sum = {1'b0, a_i} + {1'b0, b_i} + {{W{1'b0}}, cin_i};
        sum_o    = full_sum[W-1:0];
        half_o   = low_sum[HB];
        carry_o  = full_sum[W];
        ovf_o    = (a_i[W-1] == b_i[W-1]) && (full_sum[W-1] != a_i[W-1]);
    end
endmodule

// File: rtl/alu_bitop.sv
module alu_bitop #(
    parameter int W = 8,
    localparam int SW = $clog2(W)
) (
    input  logic [W-1:0]  lhs_i,
    input  logic [W-1:0]  rhs_i,
    input  logic [SW-1:0] sel_i,
    output logic [W-1:0]  and_o,
    output logic [W-1:0]  tst_o
);
    logic [W-1:0] mask;

    for (genvar g = 0; g < W; g++) begin : g_mask
        assign mask[g] = (sel_i == SW'(g));
    end

    assign and_o = lhs_i & rhs_i;
    assign tst_o = lhs_i & mask;
endmodule

// File: rtl/acc_alu.sv
module acc_alu
    import alu_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic [2:0]  op_i,
    input  logic [15:0] lhs_i,
    input  logic [15:0] rhs_i,
    input  logic [2:0]  bit_sel_i,
    input  logic [15:0] ea_i,
    input  logic [7:0]  flags_i,
    output logic [15:0] result_o,
    output logic [7:0]  flags_o
);
    alu_state_t st_d, st_q;
    alu_op_e    op;

    logic [BYTE_W-1:0] sum8;
    logic              hc8, c8, v8;
    logic [WORD_W-1:0] sum16;
    logic              hc16, c16, v16;
    logic [BYTE_W-1:0] and8, tst8;
    logic              cin8, cin16;
    logic              ea_unused;

    assign op        = alu_op_e'(op_i);
    assign cin8      = (op == OP_ADC8)  & flags_i[FL_C];
    assign cin16     = (op == OP_ADC16) & flags_i[FL_C];
    assign ea_unused = ^{ea_i[15:14], ea_i[12], ea_i[10:0]};

    alu_adder #(.W(BYTE_W), .HB(4)) u_add8 (
        .a_i(lhs_i[BYTE_W-1:0]), .b_i(rhs_i[BYTE_W-1:0]), .cin_i(cin8),
        .sum_o(sum8), .half_o(hc8), .carry_o(c8), .ovf_o(v8)
    );

    alu_adder #(.W(WORD_W), .HB(12)) u_add16 (
        .a_i(lhs_i), .b_i(rhs_i), .cin_i(cin16),
        .sum_o(sum16), .half_o(hc16), .carry_o(c16), .ovf_o(v16)
    );

    alu_bitop #(.W(BYTE_W)) u_bit (
        .lhs_i(lhs_i[BYTE_W-1:0]), .rhs_i(rhs_i[BYTE_W-1:0]), .sel_i(bit_sel_i),
        .and_o(and8), .tst_o(tst8)
    );

    always_comb begin
        st_d     = st_q;
        st_d.vld = 1'b1;
        st_d.res = lhs_i;
        st_d.flg = flags_i;
        st_d.flg[FL_N] = 1'b0;
        unique case (op)
            OP_ADD8, OP_ADC8: begin
                st_d.res        = {8'h00, sum8};
                st_d.flg[FL_S]  = sum8[7];
                st_d.flg[FL_Z]  = (sum8 == '0);
                st_d.flg[FL_U5] = sum8[5];
                st_d.flg[FL_H]  = hc8;
                st_d.flg[FL_U3] = sum8[3];
                st_d.flg[FL_PV] = v8;
                st_d.flg[FL_C]  = c8;
            end
            OP_AND8: begin
                st_d.res        = {8'h00, and8};
                st_d.flg[FL_S]  = and8[7];
                st_d.flg[FL_Z]  = (and8 == '0);
                st_d.flg[FL_U5] = and8[5];
                st_d.flg[FL_H]  = 1'b1;
                st_d.flg[FL_U3] = and8[3];
                st_d.flg[FL_PV] = even_ones(and8);
                st_d.flg[FL_C]  = 1'b0;
            end
            OP_BTST, OP_BTSTX: begin
                st_d.flg[FL_S]  = tst8[7];
                st_d.flg[FL_Z]  = (tst8 == '0);
                st_d.flg[FL_H]  = 1'b1;
                st_d.flg[FL_PV] = even_ones(tst8);
                st_d.flg[FL_U5] = (op == OP_BTSTX) ? ea_i[13] : tst8[5];
                st_d.flg[FL_U3] = (op == OP_BTSTX) ? ea_i[11] : tst8[3];
            end
            OP_CCF: begin
                st_d.flg[FL_H]  = flags_i[FL_C];
                st_d.flg[FL_C]  = ~flags_i[FL_C];
                st_d.flg[FL_U5] = flags_i[FL_U5] | lhs_i[5];
                st_d.flg[FL_U3] = flags_i[FL_U3] | lhs_i[3];
            end
            OP_ADD16, OP_ADC16: begin
                st_d.res        = sum16;
                st_d.flg[FL_U5] = sum16[13];
                st_d.flg[FL_H]  = hc16;
                st_d.flg[FL_U3] = sum16[11];
                st_d.flg[FL_C]  = c16;
                if (op == OP_ADC16) begin
                    st_d.flg[FL_S]  = sum16[15];
                    st_d.flg[FL_Z]  = (sum16 == '0);
                    st_d.flg[FL_PV] = v16;
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign result_o = st_q.res;
    assign flags_o  = st_q.flg;

    p_nclear_r2: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.vld |-> !flags_o[FL_N]);

    p_and_fixed_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.vld && $past(op_i) == OP_AND8) |-> (flags_o[FL_H] && !flags_o[FL_C]
            && result_o[15:8] == 8'h00));

    p_bit_keepc_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.vld && ($past(op_i) == OP_BTST || $past(op_i) == OP_BTSTX))
            |-> (flags_o[FL_C] == $past(flags_i[FL_C]) && result_o == $past(lhs_i)));

    p_bitx_copy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.vld && $past(op_i) == OP_BTSTX)
            |-> (flags_o[FL_U5] == $past(ea_i[13]) && flags_o[FL_U3] == $past(ea_i[11])));

    p_ccf_swap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.vld && $past(op_i) == OP_CCF)
            |-> (flags_o[FL_C] != flags_o[FL_H] && flags_o[FL_H] == $past(flags_i[FL_C])));

    p_add16_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.vld && $past(op_i) == OP_ADD16)
            |-> (flags_o[FL_S] == $past(flags_i[FL_S]) && flags_o[FL_Z] == $past(flags_i[FL_Z])
                 && flags_o[FL_PV] == $past(flags_i[FL_PV])));

endmodule

// File: tb/acc_alu_test.sv
module acc_alu_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  op = '0;
    logic [15:0] lhs = '0, rhs = '0, ea = '0;
    logic [2:0]  bsel = '0;
    logic [7:0]  fin = '0;
    logic [15:0] result;
    logic [7:0]  flags;
    int          n_chk = 0, n_bad = 0;
    bit          done = 1'b0;

    always #4 clk = ~clk;

    acc_alu uut (
        .clk(clk), .rst_n(rst_n), .op_i(op), .lhs_i(lhs), .rhs_i(rhs),
        .bit_sel_i(bsel), .ea_i(ea), .flags_i(fin),
        .result_o(result), .flags_o(flags)
    );

    task automatic check(input string tag, input logic [23:0] act, input logic [23:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // flags bit7..0: S Z U5 H U3 PV N C
    function automatic logic [23:0] model(input logic [2:0] o, input logic [15:0] l, r,
                                          input logic [2:0] bs, input logic [15:0] e,
                                          input logic [7:0] f);
        logic [15:0] res;
        logic [7:0]  nf, t;
        int ci, s, h, sv;
        res = l; nf = f; ci = int'(f[0]);
        case (o)
            3'd0, 3'd1: begin
                if (o == 3'd0) ci = 0;
                s   = int'(l[7:0]) + int'(r[7:0]) + ci;
                h   = int'(l[3:0]) + int'(r[3:0]) + ci;
                sv  = int'($signed(l[7:0])) + int'($signed(r[7:0])) + ci;
                res = {8'h00, 8'(s)};
                nf  = {res[7], res[7:0] == 8'h00, res[5], h > 15, res[3],
                       (sv > 127 || sv < -128), 1'b0, s > 255};
            end
            3'd2: begin
                t   = l[7:0] & r[7:0];
                res = {8'h00, t};
                nf  = {t[7], t == 8'h00, t[5], 1'b1, t[3], ($countones(t) % 2 == 0), 1'b0, 1'b0};
            end
            3'd3, 3'd4: begin
                t  = l[7:0] & (8'd1 << bs);
                nf = {t[7], t == 8'h00, (o == 3'd4) ? e[13] : t[5], 1'b1,
                      (o == 3'd4) ? e[11] : t[3], t == 8'h00, 1'b0, f[0]};
            end
            3'd5: nf = {f[7], f[6], f[5] | l[5], f[0], f[3] | l[3], f[2], 1'b0, ~f[0]};
            default: begin
                if (o == 3'd6) ci = 0;
                s   = int'(l) + int'(r) + ci;
                h   = int'(l[11:0]) + int'(r[11:0]) + ci;
                sv  = int'($signed(l)) + int'($signed(r)) + ci;
                res = 16'(s);
                if (o == 3'd7)
                    nf = {res[15], res == 16'h0000, res[13], h > 4095, res[11],
                          (sv > 32767 || sv < -32768), 1'b0, s > 65535};
                else
                    nf = {f[7], f[6], res[13], h > 4095, res[11], f[2], 1'b0, s > 65535};
            end
        endcase
        return {res, nf};
    endfunction

    task automatic run(input string tag, input logic [2:0] o, input logic [15:0] l, r,
                       input logic [2:0] bs, input logic [15:0] e, input logic [7:0] f);
        @(negedge clk);
        op = o; lhs = l; rhs = r; bsel = bs; ea = e; fin = f;
        @(negedge clk);
        check(tag, {result, flags}, model(o, l, r, bs, e, f));
    endtask

    task automatic t_reset_r1();
        op = 3'd0; lhs = 16'h00FF; rhs = 16'h0001; fin = 8'hFF;
        repeat (3) @(negedge clk);
        check("R1 reset outputs", {result, flags}, 24'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 latency one cycle", {result, flags}, model(3'd0, 16'h00FF, 16'h0001, 3'd0, 16'h0, 8'hFF));
    endtask

    task automatic t_add8_r3();
        run("R3 add 7F+01", 3'd0, 16'h007F, 16'h0001, 3'd0, 16'h0, 8'h00);
        check("R3 R2 literal overflow flags", {result, flags}, {16'h0080, 8'h94});
        run("R3 add FF+01", 3'd0, 16'h00FF, 16'h0001, 3'd0, 16'h0, 8'h00);
        check("R3 R2 literal wrap flags", {result, flags}, {16'h0000, 8'h51});
        run("R3 add ignores carry in", 3'd0, 16'hAB28, 16'hCD08, 3'd0, 16'h0, 8'h01);
        run("R3 adc carry in", 3'd1, 16'h000F, 16'h0000, 3'd0, 16'h0, 8'h01);
        run("R3 adc 80+80+1", 3'd1, 16'h0080, 16'h0080, 3'd0, 16'h0, 8'hFF);
        for (int i = 0; i < 40; i++)
            run("R3 adc sweep", 3'(i & 1), 16'(i * 37 + 5), 16'(i * 91 + 13), 3'd0, 16'h0, 8'(i));
    endtask

    task automatic t_and_r4();
        run("R4 and odd ones", 3'd2, 16'h00F1, 16'h0031, 3'd0, 16'h0, 8'h01);
        run("R4 and zero", 3'd2, 16'h00AA, 16'h0055, 3'd0, 16'h0, 8'hFF);
        run("R4 and full", 3'd2, 16'hFFFF, 16'hFFFF, 3'd0, 16'h0, 8'h01);
    endtask

    task automatic t_bit_r5();
        for (int b = 0; b < 8; b++) begin
            run("R5 bit set", 3'd3, 16'h00FF, 16'h0, 3'(b), 16'hFFFF, 8'h01);
            run("R5 bit clear", 3'd3, 16'h1200, 16'h0, 3'(b), 16'h0, 8'h00);
        end
        run("R5 bit keeps carry", 3'd3, 16'h0028, 16'h0, 3'd5, 16'h0, 8'hFF);
    endtask

    task automatic t_bitx_r6();
        run("R6 indexed copy from ea", 3'd4, 16'h0000, 16'h0, 3'd2, 16'h2800, 8'h00);
        run("R6 indexed ea clear", 3'd4, 16'h00FF, 16'h0, 3'd5, 16'hD7FF, 8'h01);
        run("R6 indexed mixed", 3'd4, 16'h0008, 16'h0, 3'd3, 16'h0800, 8'h00);
    endtask

    task automatic t_ccf_r7();
        for (int k = 0; k < 16; k++)
            run("R7 ccf combo", 3'd5, {8'h00, 2'b00, k[3], 1'b0, k[2], 3'b000},
                16'h0, 3'd0, 16'h0, {2'b10, k[1], 1'b0, k[0], 1'b1, 1'b1, k[0]});
    endtask

    task automatic t_add16_r8();
        run("R8 add16 half carry", 3'd6, 16'h0FFF, 16'h0001, 3'd0, 16'h0, 8'hC4);
        check("R8 literal", {result, flags}, {16'h1000, 8'hD4});
        run("R8 add16 carry out", 3'd6, 16'hFFFF, 16'h2801, 3'd0, 16'h0, 8'h01);
        run("R8 add16 ignores carry in", 3'd6, 16'h1234, 16'h4321, 3'd0, 16'h0, 8'h3B);
    endtask

    task automatic t_adc16_r9();
        run("R9 adc16 zero", 3'd7, 16'hFFFF, 16'h0000, 3'd0, 16'h0, 8'h01);
        run("R9 adc16 overflow", 3'd7, 16'h7FFF, 16'h0000, 3'd0, 16'h0, 8'h01);
        for (int i = 0; i < 20; i++)
            run("R9 adc16 sweep", 3'd7, 16'(i * 4099 + 777), 16'(i * 12345), 3'd0, 16'h0, 8'(i * 7));
    endtask

    initial begin
        t_reset_r1();
        t_add8_r3();
        t_and_r4();
        t_bit_r5();
        t_bitx_r6();
        t_ccf_r7();
        t_add16_r8();
        t_adc16_r9();
        if (!done) begin
            done = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule